// File: doc/BRIEF.md
# Preloadable 16-bit Timer/Event Counter

This block is a 16-bit up-counter with three ways to advance. It can count edges on an external input. It can count ticks of a prescaled internal clock. It can also measure how long the external input stays at its active level. The prescaler divides the qualified system clock by 1, 2, 4 and so on up to 128.

A byte-wide register bus gives access to a control register and to the count. Reading the count returns its low and high bytes. Writing the same two addresses loads a 16-bit preload value. On overflow from 0xFFFF the counter restarts from the preload value. At the same time it emits a one-cycle strobe for a downstream pin-frequency divider. An interrupt request is raised with that strobe only when an enable input is high.

The control state machine has five states:
- `ST_HALT`: stopped.
- `ST_EVENT`: counting input edges.
- `ST_TIMER`: counting prescaled ticks.
- `ST_PW_ARM`: pulse mode, waiting for the active level.
- `ST_PW_MEAS`: pulse mode, measuring.

Its transitions are:
- Any state goes to `ST_HALT` when the run bit is 0 or the mode is 00.
- `ST_HALT` goes to the state for the selected mode once running.
- `ST_EVENT` and `ST_TIMER` follow a mode rewrite.
- `ST_PW_ARM` goes to `ST_PW_MEAS` when the active level appears. That first active cycle already counts.
- `ST_PW_MEAS` goes to `ST_HALT` when the level ends. In the same edge the run bit is cleared.

Top module: `tmr16_event_timer`

## Requirements
- R1: After reset, the control register and both count bytes read 0x00, and `irq` and `ovf_strobe` are low.
- R2: The bus addresses are 0 = control, 1 = count low / preload low, 2 = count high / preload high, and 3 reads as 0x00. The control fields are:
  - bits [2:0]: prescale exponent.
  - bit 3: edge select.
  - bit 4: run.
  - bits [7:6]: mode (01 event, 10 timer, 11 pulse width, 00 off).
  - bit 5 is not stored and reads as 0.
- R3: While run is 0, a write to a preload byte also loads the same count byte. While run is 1, such a write changes only the preload value. A wrap in the same cycle as the write reloads the older preload value.
- R4: Counting starts on the second clock edge after the control write that sets run. It stops from the edge after the write that clears run.
  - In timer mode the count advances once every 2^n cycles in which `clk_en` is high, where n is the prescale exponent.
  - With `clk_en` low, it does not advance.
- R5: In event mode the count advances once per rising edge of `ev_in` when bit 3 is 0. It advances once per falling edge when bit 3 is 1.
- R6: When the counter advances from 0xFFFF, it loads the preload value. One cycle later `ovf_strobe` is high for one cycle. `irq` is high in that same cycle only if `irq_en` was high at the wrap.
- R7: In pulse-width mode the count advances on every prescaled tick while `ev_in` is at its active level (high when bit 3 is 0). When the level ends, the run bit clears by itself and counting stops.
- R8: In any clock cycle where `bus_rd` is high with address 2, the count does not advance.
- R9: With mode 00, the count does not change even when run is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | System clock qualifier feeding the prescaler |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe (address 2 freezes counting) |
| bus_rdata | output | 8 | Read data, combinational from address |
| ev_in | input | 1 | External event / pulse input |
| irq_en | input | 1 | Overflow interrupt enable |
| irq | output | 1 | Overflow interrupt request, one cycle |
| ovf_strobe | output | 1 | Overflow strobe to the pin-frequency divider |

## Verification
The overflow reload and a running preload write can land on the same clock edge. The bench arranges this by loading 0xFFF0, starting the timer undivided, and timing a low-byte preload write to the exact edge of the sixteenth tick. The count read afterwards must show the reload took the old value 0xFFF0. A second run must then wrap to the newly written 0xFF80, with exactly two strobes across both runs.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int DATA_W  = 8;
    localparam int LANES   = 2;
    localparam int CNT_W   = DATA_W * LANES;
    localparam int PSEL_W  = 3;
    localparam int ADDR_W  = 2;

    localparam int B_EDGE  = 3;
    localparam int B_RUN   = 4;
    localparam int B_MODE  = 6;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_LO   = 2'd1;
    localparam logic [ADDR_W-1:0] A_HI   = 2'd2;

    typedef enum logic [1:0] {
        MD_OFF   = 2'b00,
        MD_EVENT = 2'b01,
        MD_TIMER = 2'b10,
        MD_PULSE = 2'b11
    } mode_e;

    typedef enum logic [2:0] {
        ST_HALT,
        ST_EVENT,
        ST_TIMER,
        ST_PW_ARM,
        ST_PW_MEAS
    } state_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int DIV_W = (1 << SEL_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        mask = DIV_W'((32'd1 << sel) - 32'd1);
        tick = clk_en && ((div_q & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_q <= '0;
        else if (clk_en)
            div_q <= div_q + 1'b1;
    end
endmodule

// File: rtl/tmr_edge.sv
module tmr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic ev_in,
    input  logic fall_sel,
    output logic edge_hit,
    output logic active
);
    logic ev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ev_q <= 1'b0;
        else
            ev_q <= ev_in;
    end

    always_comb begin
        edge_hit = fall_sel ? (ev_q && !ev_in) : (!ev_q && ev_in);
        active   = ev_in ^ fall_sel;
    end
endmodule

// File: rtl/tmr_ctrl_fsm.sv
module tmr_ctrl_fsm
    import tmr_pkg::*;
#(
    parameter int DW = 8,
    parameter int SW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ctrl,
    input  logic [DW-1:0] wr_data,
    input  logic          tick,
    input  logic          edge_hit,
    input  logic          active,
    input  logic          freeze,
    output logic [DW-1:0] ctrl_rd,
    output logic          run,
    output logic [SW-1:0] ps_sel,
    output logic          fall_sel,
    output logic          count_en
);
    mode_e  mode;
    state_e state, nxt;
    logic   pw_done;
    logic   hit;

    function automatic state_e entry_for(mode_e m);
        unique case (m)
            MD_EVENT: return ST_EVENT;
            MD_TIMER: return ST_TIMER;
            MD_PULSE: return ST_PW_ARM;
            default:  return ST_HALT;
        endcase
    endfunction

    assign pw_done = run && (mode == MD_PULSE) && (state == ST_PW_MEAS) && !active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_sel   <= '0;
            fall_sel <= 1'b0;
            run      <= 1'b0;
            mode     <= MD_OFF;
        end else if (wr_ctrl) begin
            ps_sel   <= wr_data[SW-1:0];
            fall_sel <= wr_data[B_EDGE];
            run      <= wr_data[B_RUN];
            mode     <= mode_e'(wr_data[B_MODE +: 2]);
        end else if (pw_done) begin
            run      <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_HALT;
        else
            state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (!run || mode == MD_OFF) begin
            nxt = ST_HALT;
        end else begin
            unique case (state)
                ST_HALT:   nxt = entry_for(mode);
                ST_EVENT:  nxt = entry_for(mode);
                ST_TIMER:  nxt = entry_for(mode);
                ST_PW_ARM: begin
                    if (mode != MD_PULSE) nxt = entry_for(mode);
                    else if (active)      nxt = ST_PW_MEAS;
                end
                ST_PW_MEAS: begin
                    if (mode != MD_PULSE) nxt = entry_for(mode);
                    else if (!active)     nxt = ST_HALT;
                end
                default:   nxt = ST_HALT;
            endcase
        end
    end

    always_comb begin
        hit = 1'b0;
        unique case (state)
            ST_EVENT:              hit = (mode == MD_EVENT) && edge_hit;
            ST_TIMER:              hit = (mode == MD_TIMER) && tick;
            ST_PW_ARM, ST_PW_MEAS: hit = (mode == MD_PULSE) && active && tick;
            default:               hit = 1'b0;
        endcase
        count_en = run && !freeze && hit;
        ctrl_rd  = '0;
        ctrl_rd[SW-1:0]     = ps_sel;
        ctrl_rd[B_EDGE]     = fall_sel;
        ctrl_rd[B_RUN]      = run;
        ctrl_rd[B_MODE +: 2] = mode;
    end

    // R7: end of the active level in measurement stops the run bit
    p_pw_autostop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PW_MEAS && mode == MD_PULSE && run && !active && !wr_ctrl) |=> !run);

    // R7: leaving measurement without a rewrite always goes to halt
    p_pw_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PW_MEAS && !wr_ctrl && !run) |=> (state == ST_HALT));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int DW = 8,
    parameter int NL = 2,
    parameter int CW = DW * NL
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NL-1:0] wr_lane,
    input  logic [DW-1:0] wr_data,
    input  logic          running,
    input  logic          count_en,
    output logic [CW-1:0] count,
    output logic          wrap,
    output logic          ovf_q
);
    localparam logic [CW-1:0] TOP = '1;

    logic [CW-1:0] preload;

    assign wrap = count_en && (count == TOP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count   <= '0;
            preload <= '0;
            ovf_q   <= 1'b0;
        end else begin
            ovf_q <= wrap;
            for (int l = 0; l < NL; l++) begin
                if (wr_lane[l]) preload[l*DW +: DW] <= wr_data;
            end
            if (!running) begin
                for (int l = 0; l < NL; l++) begin
                    if (wr_lane[l]) count[l*DW +: DW] <= wr_data;
                end
            end else if (count_en) begin
                count <= wrap ? preload : count + 1'b1;
            end
        end
    end

    // R6: the cycle carrying the strobe shows the reloaded value
    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> (count == $past(preload)));

    // R3: a stopped counter without byte writes keeps its value
    p_stopped_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && wr_lane == '0) |=> $stable(count));
endmodule

// File: rtl/tmr16_event_timer.sv
module tmr16_event_timer
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ev_in,
    input  logic              irq_en,
    output logic              irq,
    output logic              ovf_strobe
);
    logic [DATA_W-1:0] ctrl_rd;
    logic [PSEL_W-1:0] ps_sel;
    logic              fall_sel, run, count_en;
    logic              tick, edge_hit, active, freeze;
    logic [LANES-1:0]  wr_lane;
    logic [CNT_W-1:0]  count;
    logic              wrap, irq_q;

    assign freeze     = bus_rd && (bus_addr == A_HI);
    assign wr_lane[0] = bus_wr && (bus_addr == A_LO);
    assign wr_lane[1] = bus_wr && (bus_addr == A_HI);

    tmr_prescaler #(.SEL_W(PSEL_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sel(ps_sel), .tick(tick)
    );

    tmr_edge u_edge (
        .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .fall_sel(fall_sel),
        .edge_hit(edge_hit), .active(active)
    );

    tmr_ctrl_fsm #(.DW(DATA_W), .SW(PSEL_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .wr_ctrl(bus_wr && (bus_addr == A_CTRL)), .wr_data(bus_wdata),
        .tick(tick), .edge_hit(edge_hit), .active(active), .freeze(freeze),
        .ctrl_rd(ctrl_rd), .run(run), .ps_sel(ps_sel), .fall_sel(fall_sel),
        .count_en(count_en)
    );

    tmr_counter #(.DW(DATA_W), .NL(LANES)) u_cnt (
        .clk(clk), .rst_n(rst_n), .wr_lane(wr_lane), .wr_data(bus_wdata),
        .running(run), .count_en(count_en), .count(count), .wrap(wrap),
        .ovf_q(ovf_strobe)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= wrap && irq_en;
    end
    assign irq = irq_q;

    always_comb begin
        unique case (bus_addr)
            A_CTRL:  bus_rdata = ctrl_rd;
            A_LO:    bus_rdata = count[DATA_W-1:0];
            A_HI:    bus_rdata = count[CNT_W-1:DATA_W];
            default: bus_rdata = '0;
        endcase
    end

    // R6: a request only accompanies a strobe and an enabled source
    p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ovf_strobe && $past(irq_en)));

    // R8: a high-byte read holds the count
    p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !bus_wr) |=> $stable(count));

    // R9: mode off never moves the count
    p_mode_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd[B_MODE +: 2] == 2'b00 && !bus_wr) |=> $stable(count));
endmodule

// File: tb/tmr16_event_timer_test.sv
`timescale 1ns/1ps
module tmr16_event_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_en = 1'b1;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       ev_in = 1'b0;
    logic       irq_en = 1'b0;
    logic       irq, ovf_strobe;

    int n_cmp = 0;
    int n_mis = 0;
    int n_ovf = 0;
    int n_irq = 0;
    bit done = 1'b0;

    tmr16_event_timer uut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .ev_in(ev_in), .irq_en(irq_en),
        .irq(irq), .ovf_strobe(ovf_strobe)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        if (rst_n && ovf_strobe) n_ovf++;
        if (rst_n && irq) n_irq++;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_mis++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic rd16(output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(2'd1, lo);
        rd(2'd2, hi);
        v = {hi, lo};
    endtask

    task automatic load(input logic [15:0] v);
        wr(2'd1, v[7:0]);
        wr(2'd2, v[15:8]);
    endtask

    // start, w idle cycles, stop -> w counted edges
    task automatic run_for(input logic [7:0] ctrl, input int w);
        wr(2'd0, ctrl);
        idle(w);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        logic [15:0] v;
        rd(2'd0, d);   chk("R1 ctrl after reset", d, 8'h00);
        rd16(v);       chk("R1 count after reset", v, 16'h0000);
        chk("R1 irq after reset", irq, 1'b0);
        chk("R1 strobe after reset", ovf_strobe, 1'b0);
    endtask

    task automatic t_ctrl_bits;
        logic [7:0] d;
        wr(2'd0, 8'h2F);
        rd(2'd0, d);   chk("R2 bit5 reads 0", d, 8'h0F);
        rd(2'd3, d);   chk("R2 addr3 reads 0", d, 8'h00);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_preload_stopped;
        logic [15:0] v;
        load(16'h1234);
        rd16(v);       chk("R3 stopped preload loads count", v, 16'h1234);
    endtask

    task automatic t_timer;
        logic [15:0] v;
        load(16'h0000);
        run_for(8'h90, 25);
        rd16(v);       chk("R4 timer divide-by-1", v, 16'd25);
        load(16'h0000);
        run_for(8'h93, 80);
        rd16(v);       chk("R4 timer divide-by-8", v, 16'd10);
        load(16'h0000);
        clk_en = 1'b0;
        run_for(8'h90, 12);
        clk_en = 1'b1;
        rd16(v);       chk("R4 clk_en low holds", v, 16'd0);
    endtask

    task automatic t_event;
        logic [15:0] v;
        load(16'h0000);
        wr(2'd0, 8'h50);
        idle(3);
        for (int i = 0; i < 5; i++) begin
            ev_in = 1'b1; idle(2); ev_in = 1'b0; idle(2);
        end
        idle(3);
        wr(2'd0, 8'h00);
        rd16(v);       chk("R5 rising edges", v, 16'd5);
        load(16'h0000);
        wr(2'd0, 8'h58);
        idle(3);
        for (int i = 0; i < 3; i++) begin
            ev_in = 1'b1; idle(2); ev_in = 1'b0; idle(2);
        end
        ev_in = 1'b1;
        idle(3);
        wr(2'd0, 8'h00);
        ev_in = 1'b0;
        rd16(v);       chk("R5 falling edges", v, 16'd3);
    endtask

    task automatic t_overflow;
        logic [15:0] v;
        int o0, i0;
        irq_en = 1'b1;
        load(16'hFFF0);
        o0 = n_ovf; i0 = n_irq;
        run_for(8'h90, 40);
        idle(1);
        rd16(v);       chk("R6 count after two wraps", v, 16'hFFF8);
        chk("R6 strobes", n_ovf - o0, 2);
        chk("R6 irq enabled", n_irq - i0, 2);
        irq_en = 1'b0;
        load(16'hFFF0);
        o0 = n_ovf; i0 = n_irq;
        run_for(8'h90, 40);
        idle(1);
        chk("R6 strobes irq off", n_ovf - o0, 2);
        chk("R6 irq suppressed", n_irq - i0, 0);
    endtask

    task automatic t_preload_running;
        logic [15:0] v;
        int o0;
        load(16'hFFF0);
        o0 = n_ovf;
        wr(2'd0, 8'h90);
        idle(16);
        wr(2'd1, 8'h80);   // lands on the wrap edge
        idle(2);
        wr(2'd0, 8'h00);
        rd16(v);       chk("R3 wrap uses old preload", v, 16'hFFF3);
        run_for(8'h90, 14);
        idle(1);
        rd16(v);       chk("R3 next wrap uses new preload", v, 16'hFF81);
        chk("R3 strobes across both runs", n_ovf - o0, 2);
    endtask

    task automatic t_pulse;
        logic [15:0] v;
        logic [7:0] d;
        load(16'h0000);
        wr(2'd0, 8'hD0);
        idle(3);
        ev_in = 1'b1; idle(12); ev_in = 1'b0;
        idle(4);
        rd(2'd0, d);   chk("R7 run cleared by hardware", d, 8'hC0);
        rd16(v);       chk("R7 pulse width", v, 16'd12);
        ev_in = 1'b1; idle(5); ev_in = 1'b0; idle(2);
        rd16(v);       chk("R7 no count after stop", v, 16'd12);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_freeze;
        logic [15:0] v;
        load(16'h0000);
        wr(2'd0, 8'h90);
        idle(5);
        bus_addr = 2'd2; bus_rd = 1'b1;
        idle(10);
        bus_rd = 1'b0;
        idle(5);
        wr(2'd0, 8'h00);
        rd16(v);       chk("R8 high read blocks counting", v, 16'd10);
    endtask

    task automatic t_mode_off;
        logic [15:0] v;
        logic [7:0] d;
        load(16'h0005);
        wr(2'd0, 8'h10);
        for (int i = 0; i < 4; i++) begin
            ev_in = 1'b1; idle(2); ev_in = 1'b0; idle(2);
        end
        rd(2'd0, d);   chk("R9 ctrl shows run with mode off", d, 8'h10);
        rd16(v);       chk("R9 mode off holds count", v, 16'd5);
        wr(2'd0, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_mis++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset;
        t_ctrl_bits;
        t_preload_stopped;
        t_timer;
        t_event;
        t_overflow;
        t_preload_running;
        t_pulse;
        t_freeze;
        t_mode_off;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end
endmodule